// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold Requests

This block sits between a serial shift engine and the register side of a serial peripheral controller. It holds two byte queues. The transmit queue is filled from the bus side and drained by the engine. The receive queue is filled by the engine and drained from the bus side. The depth of both queues is one parameter, normally 64 or 128.

Each direction has an 8-bit programmable threshold. When the receive occupancy reaches its threshold, or the transmit occupancy falls to its threshold, the block raises a level condition. That condition feeds a sticky status flag and, if enabled, a DMA request line. A sticky status word records these conditions together with a receive overflow and a transfer-done pulse from the engine. Software clears the flags by writing ones to them. An enable mask selects which flags drive the single interrupt line. Each queue has its own soft reset bit, which empties that queue and then clears itself.

Top module: `dual_fifo_trig`

## Requirements
- R1: Each queue returns bytes in push order, with the oldest byte shown at its head output before it is popped. A push into a full transmit queue is dropped. A pop from an empty queue has no effect on the occupancy.
- R2: The occupancy word shows the receive count in bits 7:0 and the transmit count in bits 23:16. A count changes on the clock edge at which the push or pop is sampled.
- R3: A push into a full receive queue is dropped and sets status bit 8 (overflow) at that same edge.
- R4: The receive-ready condition holds while the receive count is at least the threshold in control bits 7:0. Status bit 0 is set on the edge after the condition holds.
- R5: The transmit-empty condition holds while the transmit count is at most the threshold in control bits 23:16. Status bit 4 is set on the edge after the condition holds.
- R6: Writing a 1 to a status bit clears it at that edge, and the clear wins over a set in the same cycle. A level condition that still holds sets the bit again one edge later. Writing all ones clears every flag.
- R7: The interrupt output is high exactly when some status bit is set and its enable bit is also set. The enable word uses the same bit layout as the status word (0, 4, 8, 12).
- R8: The receive DMA request equals control bit 8 AND the receive-ready condition. The transmit DMA request equals control bit 24 AND the transmit-empty condition. Both follow the counts with no further delay.
- R9: Writing control bit 15 (receive) or bit 31 (transmit) makes that bit read back as 1 for one cycle. At the next edge the bit returns to 0 and the selected queue is emptied, while the other queue keeps its contents.
- R10: A one-cycle transfer-done pulse sets status bit 12 at the edge where the pulse is sampled.
- R11: While reset is active, the control, enable, status and occupancy words all read as zero, and the interrupt and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_tx_push | input | 1 | Bus side writes a byte into the transmit queue |
| bus_tx_data | input | 8 | Byte for the transmit queue |
| bus_rx_pop | input | 1 | Bus side removes the receive head byte |
| bus_rx_data | output | 8 | Receive queue head byte |
| eng_tx_pop | input | 1 | Engine removes the transmit head byte |
| eng_tx_data | output | 8 | Transmit queue head byte |
| eng_tx_valid | output | 1 | Transmit queue is not empty |
| eng_rx_push | input | 1 | Engine writes a byte into the receive queue |
| eng_rx_data | input | 8 | Byte for the receive queue |
| xfer_done | input | 1 | Transfer-complete pulse from the engine |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word: thresholds, DMA enables, soft resets |
| ien_we | input | 1 | Interrupt enable write strobe |
| ien_wdata | input | 32 | Interrupt enable word |
| sta_w1c_we | input | 1 | Status clear strobe |
| sta_w1c_data | input | 32 | Ones select the status bits to clear |
| ctl_q | output | 32 | Control word readback |
| lvl_q | output | 32 | Occupancy word |
| ien_q | output | 32 | Interrupt enable readback |
| sta_q | output | 32 | Status word |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Occupancy counts, head bytes and DMA requests are due one edge after the push, pop or control write that causes them. Level status bits are due one edge after that. The overflow and done bits are due at the edge that samples their cause. A soft reset shows its bit for one cycle and empties the queue at the following edge.

The bench drives inputs just after a rising edge and samples just after the next one. Each check is placed at the exact number of edges given above. For every pairing of threshold and occupancy on an eight-entry queue, the bench confirms two things: the status bit reads zero one edge after an all-ones clear, and it returns one edge later exactly when the arithmetic condition holds.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    // control word field positions (decoded by register side)
    localparam int CTL_RX_THR_LSB = 0;
    localparam int CTL_RX_DMA     = 8;
    localparam int CTL_RX_RST     = 15;
    localparam int CTL_TX_THR_LSB = 16;
    localparam int CTL_TX_DMA     = 24;
    localparam int CTL_TX_RST     = 31;

    // status / enable events: index i lives at word bit 4*i
    localparam int NUM_EVT  = 4;
    localparam int EV_RXRDY = 0;
    localparam int EV_TXEMP = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_DONE  = 3;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    typedef struct packed {
        logic       tx_rst;
        logic       tx_dma;
        logic [7:0] tx_thr;
        logic       rx_rst;
        logic       rx_dma;
        logic [7:0] rx_thr;
    } fifo_ctl_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_beat_t;

    function automatic int evt_bit(input int idx);
        return idx * 4;
    endfunction

    function automatic fifo_ctl_t ctl_from_word(input logic [31:0] w);
        fifo_ctl_t c;
        c.rx_thr = w[CTL_RX_THR_LSB +: 8];
        c.rx_dma = w[CTL_RX_DMA];
        c.rx_rst = w[CTL_RX_RST];
        c.tx_thr = w[CTL_TX_THR_LSB +: 8];
        c.tx_dma = w[CTL_TX_DMA];
        c.tx_rst = w[CTL_TX_RST];
        return c;
    endfunction

    function automatic logic [31:0] ctl_to_word(input fifo_ctl_t c);
        logic [31:0] w;
        w = '0;
        w[CTL_RX_THR_LSB +: 8] = c.rx_thr;
        w[CTL_RX_DMA]          = c.rx_dma;
        w[CTL_RX_RST]          = c.rx_rst;
        w[CTL_TX_THR_LSB +: 8] = c.tx_thr;
        w[CTL_TX_DMA]          = c.tx_dma;
        w[CTL_TX_RST]          = c.tx_rst;
        return w;
    endfunction

    function automatic evt_vec_t evt_from_word(input logic [31:0] w);
        evt_vec_t v;
        for (int i = 0; i < NUM_EVT; i++) v[i] = w[evt_bit(i)];
        return v;
    endfunction

    function automatic logic [31:0] evt_to_word(input evt_vec_t v);
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < NUM_EVT; i++) w[evt_bit(i)] = v[i];
        return w;
    endfunction

    function automatic logic [31:0] lvl_to_word(input logic [7:0] rxc, input logic [7:0] txc);
        logic [31:0] w;
        w = '0;
        w[7:0]   = rxc;
        w[23:16] = txc;
        return w;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  byte_beat_t    wr,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_C  = AW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == LAST_C) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == DEPTH_C);
    assign empty   = (count == '0);
    assign do_push = wr.valid && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr.data;
    end

    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= DEPTH_C);

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && full && !pop && !flush) |=> $stable(count));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/fifo_ctl_reg.sv
module fifo_ctl_reg
    import spi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output fifo_ctl_t   ctl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (we) begin
            ctl <= ctl_from_word(wdata);
        end else begin
            ctl.rx_rst <= 1'b0;
            ctl.tx_rst <= 1'b0;
        end
    end

    a_r9_rx_rst_self_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl.rx_rst && !we) |=> !ctl.rx_rst);

    a_r9_tx_rst_self_clear: assert property (@(posedge clk) disable iff (rst)
        (ctl.tx_rst && !we) |=> !ctl.tx_rst);

endmodule

// File: rtl/irq_status.sv
module irq_status
    import spi_fifo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  evt_vec_t    set_vec,
    input  logic        w1c_we,
    input  logic [31:0] w1c_word,
    input  logic        en_we,
    input  logic [31:0] en_word,
    output logic [31:0] sta_q,
    output logic [31:0] en_q,
    output logic        irq
);
    evt_vec_t sta, en, clr;

    assign clr = w1c_we ? evt_from_word(w1c_word) : '0;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic sta_b;
        always_ff @(posedge clk) begin
            if (rst)           sta_b <= 1'b0;
            else if (clr[i])   sta_b <= 1'b0;
            else if (set_vec[i]) sta_b <= 1'b1;
        end
        assign sta[i] = sta_b;

        a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
            clr[i] |=> !sta_b);

        a_r6_set_sticks: assert property (@(posedge clk) disable iff (rst)
            (set_vec[i] && !clr[i]) |=> sta_b);
    end

    always_ff @(posedge clk) begin
        if (rst)        en <= '0;
        else if (en_we) en <= evt_from_word(en_word);
    end

    assign sta_q = evt_to_word(sta);
    assign en_q  = evt_to_word(en);
    assign irq   = |(sta & en);

endmodule

// File: rtl/dual_fifo_trig.sv
module dual_fifo_trig
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_tx_push,
    input  logic [7:0]  bus_tx_data,
    input  logic        bus_rx_pop,
    output logic [7:0]  bus_rx_data,
    input  logic        eng_tx_pop,
    output logic [7:0]  eng_tx_data,
    output logic        eng_tx_valid,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_data,
    input  logic        xfer_done,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        ien_we,
    input  logic [31:0] ien_wdata,
    input  logic        sta_w1c_we,
    input  logic [31:0] sta_w1c_data,
    output logic [31:0] ctl_q,
    output logic [31:0] lvl_q,
    output logic [31:0] ien_q,
    output logic [31:0] sta_q,
    output logic        irq,
    output logic        rx_dma_req,
    output logic        tx_dma_req
);
    localparam int CW = $clog2(DEPTH + 1);

    fifo_ctl_t     ctl;
    byte_beat_t    tx_wr, rx_wr;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic          rx_cond, tx_cond, rx_ovf;
    evt_vec_t      evt_set;

    fifo_ctl_reg u_ctl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl   (ctl)
    );

    assign tx_wr = '{valid: bus_tx_push, data: bus_tx_data};
    assign rx_wr = '{valid: eng_rx_push, data: eng_rx_data};

    byte_fifo #(.DEPTH(DEPTH)) u_tx (
        .clk   (clk),
        .rst   (rst),
        .flush (ctl.tx_rst),
        .wr    (tx_wr),
        .pop   (eng_tx_pop),
        .head  (eng_tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    byte_fifo #(.DEPTH(DEPTH)) u_rx (
        .clk   (clk),
        .rst   (rst),
        .flush (ctl.rx_rst),
        .wr    (rx_wr),
        .pop   (bus_rx_pop),
        .head  (bus_rx_data),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign eng_tx_valid = !tx_empty;

    // threshold comparisons on widened values so any depth fits
    assign rx_cond = (32'(rx_cnt) >= 32'(ctl.rx_thr));
    assign tx_cond = (32'(tx_cnt) <= 32'(ctl.tx_thr));
    assign rx_ovf  = eng_rx_push && rx_full && !ctl.rx_rst;

    assign rx_dma_req = ctl.rx_dma && rx_cond;
    assign tx_dma_req = ctl.tx_dma && tx_cond;

    always_comb begin
        evt_set           = '0;
        evt_set[EV_RXRDY] = rx_cond;
        evt_set[EV_TXEMP] = tx_cond;
        evt_set[EV_OVF]   = rx_ovf;
        evt_set[EV_DONE]  = xfer_done;
    end

    irq_status u_sta (
        .clk      (clk),
        .rst      (rst),
        .set_vec  (evt_set),
        .w1c_we   (sta_w1c_we),
        .w1c_word (sta_w1c_data),
        .en_we    (ien_we),
        .en_word  (ien_wdata),
        .sta_q    (sta_q),
        .en_q     (ien_q),
        .irq      (irq)
    );

    assign ctl_q = ctl_to_word(ctl);
    assign lvl_q = lvl_to_word(8'(rx_cnt), 8'(tx_cnt));

    a_r3_overflow_flag: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_push && rx_full && !ctl.rx_rst &&
         !(sta_w1c_we && sta_w1c_data[evt_bit(EV_OVF)])) |=> sta_q[evt_bit(EV_OVF)]);

    a_r10_done_flag: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && !(sta_w1c_we && sta_w1c_data[evt_bit(EV_DONE)]))
        |=> sta_q[evt_bit(EV_DONE)]);

    a_r8_no_dma_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !ctl_q[CTL_RX_DMA] |-> !rx_dma_req);

    a_r1_tx_valid_matches_count: assert property (@(posedge clk) disable iff (rst)
        eng_tx_valid |-> (lvl_q[23:16] != 8'd0));

endmodule

// File: tb/dual_fifo_trig_test.sv
`timescale 1ns/100ps
module dual_fifo_trig_test;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_tx_push = 0, bus_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0, xfer_done = 0;
    logic [7:0] bus_tx_data = 0, eng_rx_data = 0;
    logic ctl_we = 0, ien_we = 0, sta_w1c_we = 0;
    logic [31:0] ctl_wdata = 0, ien_wdata = 0, sta_w1c_data = 0;
    logic [7:0] bus_rx_data, eng_tx_data;
    logic eng_tx_valid, irq, rx_dma_req, tx_dma_req;
    logic [31:0] ctl_q, lvl_q, ien_q, sta_q;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    dual_fifo_trig #(.DEPTH(D)) uut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        ctl_we = 1; ctl_wdata = v; step(); ctl_we = 0;
    endtask

    task automatic clr_sta(input logic [31:0] v);
        sta_w1c_we = 1; sta_w1c_data = v; step(); sta_w1c_we = 0;
    endtask

    task automatic wr_ien(input logic [31:0] v);
        ien_we = 1; ien_wdata = v; step(); ien_we = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step(); step();
        // R11 reset state
        chk("R11 ctl", ctl_q, 0);
        chk("R11 lvl", lvl_q, 0);
        chk("R11 ien", ien_q, 0);
        chk("R11 sta", sta_q, 0);
        chk("R11 irq", irq, 0);
        chk("R11 dma", {rx_dma_req, tx_dma_req}, 0);
        rst = 0;
        step();
        // R4/R5 with zero thresholds: both levels hold
        chk("R4 R5 post-reset sta", sta_q, 32'h11);

        // sweep threshold x occupancy (R2, R4, R5, R6, R8, R9)
        for (int thr = 0; thr <= D; thr++) begin
            wr_ctl(32'(thr) | (32'(thr) << 16) | 32'h8100_8100);
            chk("R9 both rst visible", {ctl_q[31], ctl_q[15]}, 2'b11);
            step();
            chk("R9 both rst cleared", {ctl_q[31], ctl_q[15]}, 2'b00);
            for (int occ = 0; occ <= D; occ++) begin
                chk("R2 rx count", lvl_q[7:0], occ);
                chk("R2 tx count", lvl_q[23:16], occ);
                chk("R8 rx dma", rx_dma_req, (occ >= thr));
                chk("R8 tx dma", tx_dma_req, (occ <= thr));
                clr_sta(32'hFFFF_FFFF);
                chk("R6 all-ones clear", sta_q, 0);
                step();
                chk("R4 rx ready", sta_q[0], (occ >= thr));
                chk("R5 tx empty", sta_q[4], (occ <= thr));
                if (occ < D) begin
                    bus_tx_push = 1; bus_tx_data = 8'(occ);
                    eng_rx_push = 1; eng_rx_data = 8'(occ);
                    step();
                    bus_tx_push = 0; eng_rx_push = 0;
                end
            end
        end

        // R1 transmit ordering, drop on full, pop on empty
        wr_ctl(32'h8000_8000);
        step();
        for (int i = 0; i <= D; i++) begin
            bus_tx_push = 1; bus_tx_data = 8'hA0 + 8'(i); step();
        end
        bus_tx_push = 0;
        chk("R1 tx full drop count", lvl_q[23:16], D);
        for (int i = 0; i < D; i++) begin
            chk("R1 tx head order", eng_tx_data, 8'hA0 + 8'(i));
            eng_tx_pop = 1; step(); eng_tx_pop = 0;
        end
        chk("R1 tx valid low", eng_tx_valid, 0);
        eng_tx_pop = 1; step(); eng_tx_pop = 0;
        chk("R1 pop empty count", lvl_q[23:16], 0);

        // R3 receive overflow and R7 masking
        wr_ien(32'h100);
        clr_sta(32'hFFFF_FFFF);
        for (int i = 0; i < D; i++) begin
            eng_rx_push = 1; eng_rx_data = 8'h50 + 8'(i); step();
        end
        chk("R7 irq masked", irq, 0);
        chk("R3 no ovf yet", sta_q[8], 0);
        eng_rx_data = 8'hEE; step(); eng_rx_push = 0;
        chk("R3 ovf set", sta_q[8], 1);
        chk("R3 rx count held", lvl_q[7:0], D);
        chk("R7 irq on ovf", irq, 1);
        for (int i = 0; i < D; i++) begin
            chk("R1 rx head order", bus_rx_data, 8'h50 + 8'(i));
            bus_rx_pop = 1; step(); bus_rx_pop = 0;
        end
        chk("R1 rx drained", lvl_q[7:0], 0);
        wr_ien(32'h0);
        chk("R7 irq disabled", irq, 0);
        wr_ien(32'h1);
        chk("R7 irq rx ready", irq, 1);
        wr_ien(32'h0);

        // R10 transfer done
        clr_sta(32'h1000);
        chk("R10 done clear", sta_q[12], 0);
        xfer_done = 1; step(); xfer_done = 0;
        chk("R10 done set", sta_q[12], 1);
        clr_sta(32'h1000);
        step();
        chk("R6 done stays clear", sta_q[12], 0);

        // R9 isolated receive reset
        for (int i = 0; i < 3; i++) begin
            bus_tx_push = 1; eng_rx_push = 1; step();
        end
        bus_tx_push = 0; eng_rx_push = 0;
        wr_ctl(32'h0000_8000);
        chk("R9 rx rst visible", ctl_q[15], 1);
        chk("R9 rx count before flush", lvl_q[7:0], 3);
        step();
        chk("R9 rx rst cleared", ctl_q[15], 0);
        chk("R9 rx flushed", lvl_q[7:0], 0);
        chk("R9 tx untouched", lvl_q[23:16], 3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule